// File: doc/BRIEF.md
# Scaler Viewport and Border Calculator

This block is the geometry front end of a video scaler. Once per configuration it takes a source viewport rectangle, a 4:2:0 format flag, the active display size and the destination rectangle on the display. From these it works out the rectangle of the luma plane to fetch, the matching chroma rectangle, and the four blank borders around the destination picture. These are the blank regions to the left of, to the right of, above and below the scaled image.

A one-cycle start strobe samples all inputs. On the next clock every result is presented together with a one-cycle done pulse. The results then stay unchanged until the next strobe, so downstream logic may sample them at any later time. A right or bottom border that would come out negative is forced to zero, and a clamp flag reports the event. A debug input widens the right and bottom borders by two pixels so the picture edge can be seen.

Top module: `vp_border_calc`

## Requirements
- R1: The luma viewport x, y, width and height are the source values with bit 0 cleared, which rounds each one down to an even number.
- R2: When `fmt_420` is 0 at the strobe, the chroma viewport x, y, width and height equal the luma viewport values.
- R3: When `fmt_420` is 1 at the strobe, each chroma viewport field equals the corresponding luma field divided by two.
- R4: The left border equals the destination x and the top border equals the destination y.
- R5: The right border is the active width minus destination x minus destination width. The bottom border is the active height minus destination y minus destination height.
- R6: When `dbg_pad` is 1 at the strobe, 2 is added to the right and bottom borders before the clamp is applied.
- R7: A right or bottom result below zero is output as 0, and `clamp_err` is 1 if either border was clamped. `clamp_err` is 0 when neither was clamped.
- R8: `luma_vld` is 0 exactly when the luma width or height is 0. `chroma_vld` is 0 exactly when the chroma width or height is 0.
- R9: `done` is high for exactly the one cycle that follows a cycle with `start` high, and the new results are visible in that same cycle.
- R10: While `start` is low, every result output and `clamp_err` hold their values regardless of input changes.
- R11: During reset and directly after it, `done`, both valid flags, `clamp_err` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Samples all inputs and computes results |
| fmt_420 | input | 1 | 1 selects half-resolution chroma |
| dbg_pad | input | 1 | Adds 2 to the right and bottom borders |
| src_x | input | COORD_W | Source viewport x |
| src_y | input | COORD_W | Source viewport y |
| src_w | input | COORD_W | Source viewport width |
| src_h | input | COORD_W | Source viewport height |
| act_w | input | COORD_W | Active display width |
| act_h | input | COORD_W | Active display height |
| dst_x | input | COORD_W | Destination rectangle x |
| dst_y | input | COORD_W | Destination rectangle y |
| dst_w | input | COORD_W | Destination rectangle width |
| dst_h | input | COORD_W | Destination rectangle height |
| done | output | 1 | One-cycle result-valid pulse |
| luma_x | output | COORD_W | Luma viewport x |
| luma_y | output | COORD_W | Luma viewport y |
| luma_w | output | COORD_W | Luma viewport width |
| luma_h | output | COORD_W | Luma viewport height |
| luma_vld | output | 1 | Luma viewport should be applied |
| chroma_x | output | COORD_W | Chroma viewport x |
| chroma_y | output | COORD_W | Chroma viewport y |
| chroma_w | output | COORD_W | Chroma viewport width |
| chroma_h | output | COORD_W | Chroma viewport height |
| chroma_vld | output | 1 | Chroma viewport should be applied |
| brd_left | output | COORD_W+1 | Left border |
| brd_right | output | COORD_W+1 | Right border |
| brd_top | output | COORD_W+1 | Top border |
| brd_bottom | output | COORD_W+1 | Bottom border |
| clamp_err | output | 1 | A border was clamped at zero |

## Verification
Random stimulus does not often land exactly on the zero boundary of the border clamp. The hard cases are a leftover of exactly 0, and a leftover of -1 or -2 that the debug pad lifts back to zero or above. The bench builds these cases directly by setting the destination position plus size equal to, or one or two above, the active size, and runs each case with and without the pad. A second case that is hard to reach is a 4:2:0 source of width 2 or 3. Here the luma width stays valid while the chroma width becomes 1. A source of width 1 gives a zero luma width and therefore no valid viewport. These cases are also driven directly.

// File: rtl/vpb_pkg.sv
// Package: shared constants for the viewport and border calculator.
package vpb_pkg;
    // Default coordinate width for all geometry inputs.
    localparam int unsigned VPB_COORD_W = 14;
    // Extra pixels added to the trailing borders in debug mode.
    localparam int unsigned VPB_DBG_PAD = 2;
    // Number of axes handled by the border units (horizontal, vertical).
    localparam int unsigned VPB_AXES    = 2;
endpackage

// File: rtl/vpb_viewport.sv
// Module: vpb_viewport
// Purely combinational. Rounds the source viewport down to even values and
// derives the chroma window, which is a copy in full-resolution formats and
// half-size in 4:2:0 mode. Also computes each window's apply qualifier.
// Assumes: unsigned coordinates of width W.
module vpb_viewport #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] src_x,
    input  logic [W-1:0] src_y,
    input  logic [W-1:0] src_w,
    input  logic [W-1:0] src_h,
    input  logic         half_chroma,
    output logic [W-1:0] l_x,
    output logic [W-1:0] l_y,
    output logic [W-1:0] l_w,
    output logic [W-1:0] l_h,
    output logic         l_vld,
    output logic [W-1:0] c_x,
    output logic [W-1:0] c_y,
    output logic [W-1:0] c_w,
    output logic [W-1:0] c_h,
    output logic         c_vld
);
    localparam logic [W-1:0] EVEN_MASK = {{(W-1){1'b1}}, 1'b0};

    // Even-align the luma window.
    always_comb begin
        l_x = src_x & EVEN_MASK;
        l_y = src_y & EVEN_MASK;
        l_w = src_w & EVEN_MASK;
        l_h = src_h & EVEN_MASK;
    end

    // Derive the chroma window from the aligned luma window.
    always_comb begin
        if (half_chroma) begin
            c_x = l_x >> 1;
            c_y = l_y >> 1;
            c_w = l_w >> 1;
            c_h = l_h >> 1;
        end else begin
            c_x = l_x;
            c_y = l_y;
            c_w = l_w;
            c_h = l_h;
        end
    end

    // A window with no area is not to be applied.
    always_comb begin
        l_vld = (l_w != '0) && (l_h != '0);
        c_vld = (c_w != '0) && (c_h != '0);
    end
endmodule

// File: rtl/vpb_border.sv
// Module: vpb_border
// Combinational border unit for one axis. The leading border is the
// destination offset. The trailing border is what is left of the active
// span after the destination, plus an optional debug pad, clamped at zero.
// Assumes: unsigned inputs of width W; signed math on W+2 bits cannot overflow.
module vpb_border #(
    parameter int unsigned W   = 14,
    parameter int unsigned PAD = 2
) (
    input  logic [W-1:0] span,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] size,
    input  logic         pad_en,
    output logic [W:0]   lead,
    output logic [W:0]   trail,
    output logic         clamped
);
    localparam int unsigned SW = W + 2;

    logic signed [SW-1:0] rest;

    // Leftover span after the destination, with the optional pad.
    always_comb begin
        rest = $signed({2'b00, span}) - $signed({2'b00, pos}) - $signed({2'b00, size});
        if (pad_en) begin
            rest = rest + SW'(PAD);
        end
    end

    // Clamp negative leftovers to zero and flag it.
    always_comb begin
        lead    = {1'b0, pos};
        clamped = rest[SW-1];
        trail   = clamped ? '0 : rest[W:0];
    end
endmodule

// File: rtl/vp_border_calc.sv
// Module: vp_border_calc
// Top of the scaler geometry unit. A start strobe samples all inputs. The
// luma and chroma viewports and the four borders are registered together
// one cycle later, with a done pulse. Results hold until the next strobe.
// Assumes: start is a single-cycle strobe; inputs are valid while it is high.
module vp_border_calc
    import vpb_pkg::*;
#(
    parameter int unsigned COORD_W = VPB_COORD_W,
    parameter int unsigned PAD     = VPB_DBG_PAD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               fmt_420,
    input  logic               dbg_pad,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] src_w,
    input  logic [COORD_W-1:0] src_h,
    input  logic [COORD_W-1:0] act_w,
    input  logic [COORD_W-1:0] act_h,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] dst_w,
    input  logic [COORD_W-1:0] dst_h,
    output logic               done,
    output logic [COORD_W-1:0] luma_x,
    output logic [COORD_W-1:0] luma_y,
    output logic [COORD_W-1:0] luma_w,
    output logic [COORD_W-1:0] luma_h,
    output logic               luma_vld,
    output logic [COORD_W-1:0] chroma_x,
    output logic [COORD_W-1:0] chroma_y,
    output logic [COORD_W-1:0] chroma_w,
    output logic [COORD_W-1:0] chroma_h,
    output logic               chroma_vld,
    output logic [COORD_W:0]   brd_left,
    output logic [COORD_W:0]   brd_right,
    output logic [COORD_W:0]   brd_top,
    output logic [COORD_W:0]   brd_bottom,
    output logic               clamp_err
);
    localparam int unsigned NAX = VPB_AXES;
    localparam int unsigned BW  = COORD_W + 1;

    // Combinational viewport results.
    logic [COORD_W-1:0] n_lx, n_ly, n_lw, n_lh, n_cx, n_cy, n_cw, n_ch;
    logic               n_lvld, n_cvld;

    vpb_viewport #(.W(COORD_W)) u_vp (
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .half_chroma(fmt_420),
        .l_x(n_lx), .l_y(n_ly), .l_w(n_lw), .l_h(n_lh), .l_vld(n_lvld),
        .c_x(n_cx), .c_y(n_cy), .c_w(n_cw), .c_h(n_ch), .c_vld(n_cvld)
    );

    // Per-axis border inputs and results (index 0 horizontal, 1 vertical).
    logic [COORD_W-1:0] ax_span [NAX];
    logic [COORD_W-1:0] ax_pos  [NAX];
    logic [COORD_W-1:0] ax_size [NAX];
    logic [BW-1:0]      ax_lead [NAX];
    logic [BW-1:0]      ax_trail[NAX];
    logic [NAX-1:0]     ax_clamp;

    // Route the geometry of each axis to its border unit.
    always_comb begin
        ax_span[0] = act_w; ax_pos[0] = dst_x; ax_size[0] = dst_w;
        ax_span[1] = act_h; ax_pos[1] = dst_y; ax_size[1] = dst_h;
    end

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        vpb_border #(.W(COORD_W), .PAD(PAD)) u_brd (
            .span(ax_span[g]), .pos(ax_pos[g]), .size(ax_size[g]),
            .pad_en(dbg_pad),
            .lead(ax_lead[g]), .trail(ax_trail[g]), .clamped(ax_clamp[g])
        );
    end

    // Generate the done pulse one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

    // Latch all results together on the strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            luma_x <= '0; luma_y <= '0; luma_w <= '0; luma_h <= '0; luma_vld <= 1'b0;
            chroma_x <= '0; chroma_y <= '0; chroma_w <= '0; chroma_h <= '0; chroma_vld <= 1'b0;
            brd_left <= '0; brd_right <= '0; brd_top <= '0; brd_bottom <= '0;
            clamp_err <= 1'b0;
        end else if (start) begin
            luma_x <= n_lx; luma_y <= n_ly; luma_w <= n_lw; luma_h <= n_lh; luma_vld <= n_lvld;
            chroma_x <= n_cx; chroma_y <= n_cy; chroma_w <= n_cw; chroma_h <= n_ch;
            chroma_vld <= n_cvld;
            brd_left <= ax_lead[0]; brd_right <= ax_trail[0];
            brd_top <= ax_lead[1]; brd_bottom <= ax_trail[1];
            clamp_err <= |ax_clamp;
        end
    end

    // R1: every registered luma field is even.
    a_r1_even_luma: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (luma_x[0] == 1'b0 && luma_y[0] == 1'b0 && luma_w[0] == 1'b0 && luma_h[0] == 1'b0));

    // R2: chroma equals luma outside 4:2:0.
    a_r2_chroma_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(fmt_420)) |-> (chroma_x == luma_x && chroma_w == luma_w
                                       && chroma_y == luma_y && chroma_h == luma_h));

    // R3: chroma is half of luma in 4:2:0.
    a_r3_chroma_half: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(fmt_420)) |-> ({chroma_w, 1'b0} == {1'b0, luma_w}
                                      && {chroma_h, 1'b0} == {1'b0, luma_h}));

    // R8: qualifiers reflect non-zero area.
    a_r8_vld_area: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (luma_vld == (luma_w != '0 && luma_h != '0)
                  && chroma_vld == (chroma_w != '0 && chroma_h != '0)));

    // R9: done follows exactly one strobe.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    // R10: results hold without a strobe.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(luma_x) && $stable(chroma_w) && $stable(brd_right)
                    && $stable(brd_bottom) && $stable(clamp_err) && $stable(luma_vld)));
endmodule

// File: tb/vp_border_calc_tb.sv
// Bench for vp_border_calc: directed corners plus seeded random stimulus.
module vp_border_calc_tb;
    localparam int W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, fmt_420 = 1'b0, dbg_pad = 1'b0;
    logic [W-1:0] src_x = '0, src_y = '0, src_w = '0, src_h = '0;
    logic [W-1:0] act_w = '0, act_h = '0, dst_x = '0, dst_y = '0, dst_w = '0, dst_h = '0;
    logic done, luma_vld, chroma_vld, clamp_err;
    logic [W-1:0] luma_x, luma_y, luma_w, luma_h, chroma_x, chroma_y, chroma_w, chroma_h;
    logic [W:0] brd_left, brd_right, brd_top, brd_bottom;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vp_border_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_420(fmt_420), .dbg_pad(dbg_pad),
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .act_w(act_w), .act_h(act_h), .dst_x(dst_x), .dst_y(dst_y),
        .dst_w(dst_w), .dst_h(dst_h), .done(done),
        .luma_x(luma_x), .luma_y(luma_y), .luma_w(luma_w), .luma_h(luma_h),
        .luma_vld(luma_vld), .chroma_x(chroma_x), .chroma_y(chroma_y),
        .chroma_w(chroma_w), .chroma_h(chroma_h), .chroma_vld(chroma_vld),
        .brd_left(brd_left), .brd_right(brd_right), .brd_top(brd_top),
        .brd_bottom(brd_bottom), .clamp_err(clamp_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ev(input int v);
        return v & ~1;
    endfunction

    function automatic int trail(input int span, input int pos, input int size, input bit pad);
        int r;
        r = span - pos - size + (pad ? 2 : 0);
        return (r < 0) ? 0 : r;
    endfunction

    function automatic bit neg(input int span, input int pos, input int size, input bit pad);
        return (span - pos - size + (pad ? 2 : 0)) < 0;
    endfunction

    // Compare all outputs with the model for the inputs currently applied.
    task automatic check_all();
        int lx, ly, lw, lh, cx, cy, cw, ch;
        lx = ev(int'(src_x)); ly = ev(int'(src_y)); lw = ev(int'(src_w)); lh = ev(int'(src_h));
        cx = fmt_420 ? lx / 2 : lx; cy = fmt_420 ? ly / 2 : ly;
        cw = fmt_420 ? lw / 2 : lw; ch = fmt_420 ? lh / 2 : lh;
        chk("R9 done", int'(done), 1);
        chk("R1 luma_x", int'(luma_x), lx);
        chk("R1 luma_y", int'(luma_y), ly);
        chk("R1 luma_w", int'(luma_w), lw);
        chk("R1 luma_h", int'(luma_h), lh);
        chk(fmt_420 ? "R3 chroma_x" : "R2 chroma_x", int'(chroma_x), cx);
        chk(fmt_420 ? "R3 chroma_y" : "R2 chroma_y", int'(chroma_y), cy);
        chk(fmt_420 ? "R3 chroma_w" : "R2 chroma_w", int'(chroma_w), cw);
        chk(fmt_420 ? "R3 chroma_h" : "R2 chroma_h", int'(chroma_h), ch);
        chk("R8 luma_vld", int'(luma_vld), int'(lw != 0 && lh != 0));
        chk("R8 chroma_vld", int'(chroma_vld), int'(cw != 0 && ch != 0));
        chk("R4 brd_left", int'(brd_left), int'(dst_x));
        chk("R4 brd_top", int'(brd_top), int'(dst_y));
        chk("R5 R6 brd_right", int'(brd_right), trail(int'(act_w), int'(dst_x), int'(dst_w), dbg_pad));
        chk("R5 R6 brd_bottom", int'(brd_bottom), trail(int'(act_h), int'(dst_y), int'(dst_h), dbg_pad));
        chk("R7 clamp_err", int'(clamp_err),
            int'(neg(int'(act_w), int'(dst_x), int'(dst_w), dbg_pad)
               || neg(int'(act_h), int'(dst_y), int'(dst_h), dbg_pad)));
    endtask

    // Apply a strobe with the current inputs and check the results.
    task automatic run_one();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_all();
    endtask

    task automatic set_all(input bit f, input bit p, input int sx, input int sy, input int sw,
                           input int sh, input int aw, input int ah, input int ox, input int oy,
                           input int ow, input int oh);
        fmt_420 = f; dbg_pad = p;
        src_x = W'(sx); src_y = W'(sy); src_w = W'(sw); src_h = W'(sh);
        act_w = W'(aw); act_h = W'(ah); dst_x = W'(ox); dst_y = W'(oy);
        dst_w = W'(ow); dst_h = W'(oh);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R11: reset values.
        chk("R11 done", int'(done), 0);
        chk("R11 luma_vld", int'(luma_vld), 0);
        chk("R11 chroma_vld", int'(chroma_vld), 0);
        chk("R11 clamp_err", int'(clamp_err), 0);
        chk("R11 luma_w", int'(luma_w), 0);
        chk("R11 brd_right", int'(brd_right), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 done after reset", int'(done), 0);

        // Directed: odd source, full-resolution, exact fit.
        set_all(0, 0, 7, 9, 101, 55, 1920, 1080, 0, 0, 1920, 1080);
        run_one();
        // R9: done lasts one cycle.
        @(negedge clk);
        chk("R9 done pulse width", int'(done), 0);
        // 4:2:0 with width 3 -> luma 2, chroma 1.
        set_all(1, 0, 5, 3, 3, 3, 100, 100, 10, 10, 50, 50);
        run_one();
        // Width 1 -> luma width 0, not valid.
        set_all(0, 0, 0, 0, 1, 40, 100, 100, 0, 0, 100, 100);
        run_one();
        // Height zero in 4:2:0.
        set_all(1, 0, 2, 2, 64, 0, 100, 100, 0, 0, 100, 100);
        run_one();
        // Leftover -1 lifted by pad; -2 lifted to 0; -3 still clamps.
        set_all(0, 1, 0, 0, 8, 8, 100, 100, 50, 20, 51, 82);
        run_one();
        set_all(0, 0, 0, 0, 8, 8, 100, 100, 50, 20, 51, 82);
        run_one();
        set_all(0, 1, 0, 0, 8, 8, 100, 100, 50, 20, 53, 80);
        run_one();
        // Largest inputs with pad.
        set_all(1, 1, 16383, 16383, 16383, 16383, 16383, 16383, 16383, 0, 16383, 0);
        run_one();

        // R10: inputs change without strobe; outputs hold.
        begin
            int hold_w, hold_r, hold_c;
            hold_w = int'(luma_w); hold_r = int'(brd_right); hold_c = int'(clamp_err);
            set_all(0, 0, 2, 2, 40, 40, 1000, 1000, 0, 0, 10, 10);
            repeat (3) @(negedge clk);
            chk("R10 luma_w hold", int'(luma_w), hold_w);
            chk("R10 brd_right hold", int'(brd_right), hold_r);
            chk("R10 clamp_err hold", int'(clamp_err), hold_c);
            chk("R10 no done", int'(done), 0);
        end

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            int aw, ah;
            aw = int'($urandom_range(4000, 16));
            ah = int'($urandom_range(4000, 16));
            set_all(bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
                    int'($urandom_range(4000, 0)), int'($urandom_range(4000, 0)),
                    int'($urandom_range(4000, 0)), int'($urandom_range(4000, 0)),
                    aw, ah,
                    int'($urandom_range(aw, 0)), int'($urandom_range(ah, 0)),
                    int'($urandom_range(aw + 4, 0)) - 0, int'($urandom_range(ah + 4, 0)));
            run_one();
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule